// File: doc/BRIEF.md
# Receive FIFO auto-RTS controller

This block sits beside the receive FIFO of a UART channel and drives that channel's active-low request-to-send pin. It reads the FIFO fill count every cycle and compares it with two thresholds. Both thresholds come from one 8-bit trigger control byte. When the count climbs to the stop threshold, the pin goes high and the remote sender pauses. The pin goes low again only after the count has drained to the restart threshold. The gap between the two thresholds gives hysteresis, so the pin does not chatter while the FIFO hovers near one level.

The sender may not see the pin change until it has already started one more byte. The stop threshold therefore always leaves room below a full FIFO for that byte. If a byte is pushed while the FIFO already holds its full capacity and nothing is popped in the same cycle, the block raises a one-cycle overrun pulse.

With automatic control turned off, the pin copies a host-owned bit. The threshold state keeps tracking the FIFO in the meantime, so turning automatic control back on takes effect without a settling period. This block has no data stream: every pin is a plain level or strobe, so there are no valid/ready handshakes and no back-pressure rules.

Top module: `rx_rts_ctrl`

## Requirements
- R1: While reset is asserted, and until the first clock edge after reset is released, `rts_n` is 1 and `overrun` is 0.
- R2: The stop threshold in bytes is `trig_ctl[3:0]` times 4. The restart threshold in bytes is `trig_ctl[7:4]` times 4.
- R3: With `auto_en` = 1, a clock edge at which `fifo_count` is at or above the stop threshold makes `rts_n` 1 after that edge.
- R4: With `auto_en` = 1, a clock edge at which `fifo_count` is below the stop threshold and at or below the restart threshold makes `rts_n` 0 after that edge.
- R5: With `auto_en` = 1, a count strictly between the restart and stop thresholds leaves `rts_n` at its previous value.
- R6: When the programmed restart threshold is not below the stop threshold, the restart threshold used is the stop threshold minus 4. When the stop threshold is 0, the restart threshold used is 0 and the pin stays high.
- R7: With `auto_en` = 0, `rts_n` takes the value of `host_rts_n` at each clock edge. The threshold state keeps updating from the count during this time.
- R8: `overrun` is 1 for exactly the cycle after an edge at which `fifo_push` = 1, `fifo_pop` = 0 and `fifo_count` = 64. A push at any lower count, including the extra byte after a stop, gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_en | input | 1 | 1 selects automatic threshold control of the pin |
| host_rts_n | input | 1 | Host-owned pin value, used while `auto_en` = 0 |
| trig_ctl | input | 8 | [3:0] stop threshold /4, [7:4] restart threshold /4 |
| fifo_count | input | 7 | Current receive FIFO fill, 0 to 64 |
| fifo_push | input | 1 | Byte written into the FIFO this cycle |
| fifo_pop | input | 1 | Byte read from the FIFO this cycle |
| rts_n | output | 1 | Request to send, 0 = ready, 1 = stop |
| overrun | output | 1 | One-cycle pulse on a push into a full FIFO |

## Verification
The bench builds the block with its default 64-byte depth and a threshold step of 4. This makes the full nibble range reachable, up to a stop threshold of 60, and lets the count reach exactly 64 for the overrun case. The stimulus programs a valid threshold pair, a pair whose restart value lies above its stop value, and a zero stop threshold. For each setting it ramps the count up through the stop threshold and back down through the hysteresis band.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic {
    RTS_GO   = 1'b0,
    RTS_STOP = 1'b1
  } rts_lvl_e;
endpackage

// File: rtl/rts_level_decode.sv
module rts_level_decode #(
  parameter int CNT_W = 7,
  parameter int NIB_W = 4,
  parameter int STEP  = 4
) (
  input  logic [2*NIB_W-1:0] trig_ctl,
  output logic [CNT_W-1:0]   stop_lvl,
  output logic [CNT_W-1:0]   go_lvl
);
  logic [CNT_W-1:0] go_raw;

  always_comb begin
    stop_lvl = CNT_W'(trig_ctl[NIB_W-1:0]) * CNT_W'(STEP);
    go_raw   = CNT_W'(trig_ctl[2*NIB_W-1:NIB_W]) * CNT_W'(STEP);
    if (go_raw < stop_lvl)
      go_lvl = go_raw;
    else if (stop_lvl >= CNT_W'(STEP))
      go_lvl = stop_lvl - CNT_W'(STEP);
    else
      go_lvl = '0;
  end

  // R6
  always_comb begin
    go_below_stop_chk: assert (stop_lvl == '0 || go_lvl < stop_lvl);
  end
endmodule

// File: rtl/rts_hyst.sv
module rts_hyst #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [CNT_W-1:0] stop_lvl,
  input  logic [CNT_W-1:0] go_lvl,
  output rts_pkg::rts_lvl_e state_d,
  output rts_pkg::rts_lvl_e state_q
);
  import rts_pkg::*;

  always_comb begin
    if (fifo_count >= stop_lvl)
      state_d = RTS_STOP;
    else if (fifo_count <= go_lvl)
      state_d = RTS_GO;
    else
      state_d = state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RTS_STOP;
    else        state_q <= state_d;
  end

  // R3
  stop_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count >= stop_lvl) |=> (state_q == RTS_STOP));
  // R4
  go_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count < stop_lvl && fifo_count <= go_lvl) |=> (state_q == RTS_GO));
  // R5
  band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count > go_lvl && fifo_count < stop_lvl) |=> $stable(state_q));
endmodule

// File: rtl/rts_overrun_det.sv
module rts_overrun_det #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             fifo_push,
  input  logic             fifo_pop,
  output logic             overrun
);
  logic full;
  assign full = (fifo_count == CNT_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun <= 1'b0;
    else        overrun <= fifo_push & ~fifo_pop & full;
  end

  // R8
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(fifo_push && !fifo_pop && fifo_count == CNT_W'(DEPTH)));
  // R8
  ovr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push && !fifo_pop && fifo_count == CNT_W'(DEPTH)) |=> overrun);
endmodule

// File: rtl/rx_rts_ctrl.sv
module rx_rts_ctrl #(
  parameter int DEPTH = 64,
  parameter int NIB_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int STEP  = DEPTH / (1 << NIB_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               auto_en,
  input  logic               host_rts_n,
  input  logic [2*NIB_W-1:0] trig_ctl,
  input  logic [CNT_W-1:0]   fifo_count,
  input  logic               fifo_push,
  input  logic               fifo_pop,
  output logic               rts_n,
  output logic               overrun
);
  import rts_pkg::*;

  logic [CNT_W-1:0] stop_lvl;
  logic [CNT_W-1:0] go_lvl;
  rts_lvl_e         state_d;
  rts_lvl_e         state_q;

  rts_level_decode #(.CNT_W(CNT_W), .NIB_W(NIB_W), .STEP(STEP)) i_decode (
    .trig_ctl (trig_ctl),
    .stop_lvl (stop_lvl),
    .go_lvl   (go_lvl)
  );

  rts_hyst #(.CNT_W(CNT_W)) i_hyst (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_count (fifo_count),
    .stop_lvl   (stop_lvl),
    .go_lvl     (go_lvl),
    .state_d    (state_d),
    .state_q    (state_q)
  );

  rts_overrun_det #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_ovr (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_count (fifo_count),
    .fifo_push  (fifo_push),
    .fifo_pop   (fifo_pop),
    .overrun    (overrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rts_n <= 1'b1;
    else if (auto_en) rts_n <= (state_d == RTS_STOP);
    else              rts_n <= host_rts_n;
  end

  // R7
  host_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (rts_n == $past(host_rts_n)));
  // R3
  pin_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && fifo_count >= stop_lvl) |=> rts_n);
  // R5
  pin_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en |=> (rts_n == (state_q == RTS_STOP)));
endmodule

// File: tb/test_rx_rts_ctrl.sv
`timescale 1ns/1ps
module test_rx_rts_ctrl;
  localparam int DEPTH = 64;
  localparam int CW    = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          auto_en = 1'b0;
  logic          host_rts_n = 1'b1;
  logic [7:0]    trig_ctl = 8'h00;
  logic [CW-1:0] fifo_count = '0;
  logic          fifo_push = 1'b0;
  logic          fifo_pop = 1'b0;
  logic          rts_n;
  logic          overrun;

  always #2 clk = ~clk;

  rx_rts_ctrl i_rx_rts_ctrl (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .host_rts_n(host_rts_n),
    .trig_ctl(trig_ctl), .fifo_count(fifo_count), .fifo_push(fifo_push),
    .fifo_pop(fifo_pop), .rts_n(rts_n), .overrun(overrun)
  );

  int    checks = 0;
  int    errors = 0;
  string phase = "R1";
  bit    started = 0;
  bit    m_stop = 1'b1;
  bit    m_rts = 1'b1;
  bit    m_ovr = 1'b0;
  int    h, r, c;

  // Behavioural reference: thresholds from R2/R6, hysteresis from R3-R5
  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_stop = 1'b1; m_rts = 1'b1; m_ovr = 1'b0;
    end else begin
      h = int'(trig_ctl[3:0]) * 4;
      r = int'(trig_ctl[7:4]) * 4;
      if (r >= h) r = h - 4;
      c = int'(fifo_count);
      if (c >= h)      m_stop = 1'b1;
      else if (c <= r) m_stop = 1'b0;
      m_rts = auto_en ? m_stop : host_rts_n;
      m_ovr = fifo_push && !fifo_pop && (c == DEPTH);
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (rts_n !== m_rts) begin
        errors++;
        $display("FAIL %s rts_n count=%0d actual=%b expected=%b", phase, fifo_count, rts_n, m_rts);
      end
      checks++;
      if (overrun !== m_ovr) begin
        errors++;
        $display("FAIL %s overrun count=%0d actual=%b expected=%b", phase, fifo_count, overrun, m_ovr);
      end
    end
  end

  task automatic ramp(input int lo, input int hi, input bit up);
    if (up) for (int i = lo; i <= hi; i++) begin fifo_count = CW'(i); @(negedge clk); end
    else    for (int i = hi; i >= lo; i--) begin fifo_count = CW'(i); @(negedge clk); end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    phase = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: host bit drives the pin while automatic control is off
    phase = "R7";
    for (int i = 0; i < 6; i++) begin host_rts_n = i[0]; fifo_count = CW'(i * 10); @(negedge clk); end
    // R2 R3: stop at 32, restart at 8
    phase = "R3";
    trig_ctl = 8'h28;
    fifo_count = '0;
    auto_en = 1'b1;
    ramp(0, 40, 1'b1);
    // R5: band between 8 and 32 keeps the pin high
    phase = "R5";
    ramp(9, 40, 1'b0);
    // R4: restart at or below 8
    phase = "R4";
    ramp(0, 8, 1'b0);
    phase = "R5";
    ramp(9, 31, 1'b1);
    ramp(9, 31, 1'b0);
    // R8: extra byte after stop, below full, no pulse
    phase = "R8";
    fifo_count = CW'(33); fifo_push = 1'b1; @(negedge clk);
    fifo_count = CW'(64); @(negedge clk);
    fifo_pop = 1'b1; @(negedge clk);
    fifo_pop = 1'b0; fifo_push = 1'b0; @(negedge clk);
    fifo_count = CW'(63); fifo_push = 1'b1; @(negedge clk);
    fifo_count = CW'(64); @(negedge clk);
    fifo_push = 1'b0; @(negedge clk);
    // R6: restart programmed above stop (stop 20, restart 40 -> 16)
    phase = "R6";
    trig_ctl = 8'hA5;
    ramp(0, 24, 1'b0);
    ramp(0, 24, 1'b1);
    ramp(12, 24, 1'b0);
    // R6: zero stop threshold keeps the pin high
    trig_ctl = 8'h30;
    ramp(0, 6, 1'b0);
    // R2: top nibble range, stop 60, restart 56
    phase = "R2";
    trig_ctl = 8'hEF;
    ramp(0, 64, 1'b1);
    ramp(50, 64, 1'b0);
    // R7: tracking continues while off, then re-enable mid-band
    phase = "R7";
    auto_en = 1'b0; host_rts_n = 1'b0;
    ramp(57, 62, 1'b1);
    auto_en = 1'b1; fifo_count = CW'(58);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule